// File: doc/BRIEF.md
# Tightly Coupled Memory Region Controller

This block sits between a processor's instruction and data request ports and two local single-cycle memories: a 16 KB code store and an 8 KB data store. Each store owns a control register holding an enable flag, a size code and a 4 KB aligned base address. An access whose address lies inside an enabled window is steered onto that memory's strobes in the same cycle. It is accepted at once and flagged as non-cacheable. Any other access passes unchanged to a forward channel that leads to the cache and bus path.

Both windows are off after reset. Firmware must program the two registers before any local access can happen. The data port can also reach the code store, so that firmware can copy code into it. When the data port and the instruction port want the code store in the same cycle, the data port takes it and the fetch waits.

Request ports and forward channels follow valid/ready rules. A requester holds valid and its fields steady until ready is high at a clock edge. A forwarded request takes its ready straight from the forward channel's ready, so back-pressure from the cache/bus path reaches the requester in the same cycle. A request that hits a local memory never sees back-pressure, except when a fetch loses the code store to the data port.

Top module: `tcm_region_ctrl`

## Requirements
- R1: After reset both windows are disabled. Every request on either port goes to its forward channel, and no memory strobe is raised.
- R2: Register format: bit 0 is enable, bits [5:2] hold a size code n, and bits [31:12] hold the base address. Code n gives a window of 2^(n-1) KB, so 4 gives 8 KB and 5 gives 16 KB. Code 0 gives an empty window. cfg_sel 0 writes the code-store register and cfg_sel 1 writes the data-store register. A write becomes effective in the cycle after the clock edge that captures it.
- R3: A fetch inside the enabled code window raises itcm_en with itcm_we low. itcm_idx is set to bits [13:2] of (address − base). i_ready and i_uncached are high in that cycle, and i_fwd_valid stays low.
- R4: A data access inside the enabled data window raises dtcm_en. dtcm_we follows d_we. dtcm_idx is set to bits [12:2] of (address − base). dtcm_be and dtcm_wdata pass through. d_ready and d_uncached are high in that cycle.
- R5: A data access inside the enabled code window uses the code store. It raises itcm_en with itcm_we = d_we and carries the data port's index, byte enables and write data. d_ready and d_uncached are high.
- R6: When a fetch and a data access both target the code store in one cycle, the data access drives the code store and i_ready is low. The fetch completes in the first later cycle in which the data port does not target the code store.
- R7: A request outside every enabled window, or aimed at a disabled window, raises its forward valid. Address, write flag, byte enables and write data are copied unchanged. ready equals the forward ready, and uncached is low.
- R8: A data address that lies inside both windows goes to the data store.
- R9: When a window is programmed larger than its memory, the index wraps modulo the memory's word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects code-store register, 1 selects data-store register |
| cfg_wdata | input | 32 | Register write value |
| i_valid | input | 1 | Fetch request valid |
| i_ready | output | 1 | Fetch request accepted |
| i_addr | input | 32 | Fetch byte address |
| i_uncached | output | 1 | Fetch served locally, non-cacheable |
| i_fwd_valid | output | 1 | Fetch forwarded to cache/bus |
| i_fwd_ready | input | 1 | Cache/bus accepts fetch |
| i_fwd_addr | output | 32 | Forwarded fetch address |
| d_valid | input | 1 | Data request valid |
| d_ready | output | 1 | Data request accepted |
| d_we | input | 1 | Data write |
| d_be | input | 4 | Data byte enables |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Data write value |
| d_uncached | output | 1 | Data request served locally, non-cacheable |
| d_fwd_valid | output | 1 | Data request forwarded |
| d_fwd_ready | input | 1 | Cache/bus accepts data request |
| d_fwd_we | output | 1 | Forwarded write flag |
| d_fwd_be | output | 4 | Forwarded byte enables |
| d_fwd_addr | output | 32 | Forwarded address |
| d_fwd_wdata | output | 32 | Forwarded write value |
| itcm_en | output | 1 | Code store access strobe |
| itcm_we | output | 1 | Code store write |
| itcm_be | output | 4 | Code store byte enables |
| itcm_idx | output | 12 | Code store word index |
| itcm_wdata | output | 32 | Code store write value |
| dtcm_en | output | 1 | Data store access strobe |
| dtcm_we | output | 1 | Data store write |
| dtcm_be | output | 4 | Data store byte enables |
| dtcm_idx | output | 11 | Data store word index |
| dtcm_wdata | output | 32 | Data store write value |

## Verification
The hardest situations to reach from the ports are the ones that depend on register contents. Examples are a data address inside both windows, a window larger than its memory, and a fetch colliding with a data access to the code store. Each of these needs a particular register setting together with matching addresses on both ports in the same cycle. The stimulus programs overlapping and oversized windows directly and then drives both ports at addresses drawn close to the programmed bases. Random register values are mixed in so that window edges, empty size codes and disabled windows all occur. A directed check drives a register write and a request in the same cycle to confirm that the old setting still applies until the edge.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned BEW = DW / 8;
  localparam int unsigned NUM_RGN = 2;
  localparam int unsigned RGN_CODE = 0;
  localparam int unsigned RGN_DATA = 1;

  typedef struct packed {
    logic [19:0] base_hi;
    logic [3:0]  size_code;
    logic        en;
  } rgn_cfg_t;

  function automatic rgn_cfg_t unpack_cfg(input logic [31:0] w);
    rgn_cfg_t c;
    c.base_hi   = w[31:12];
    c.size_code = w[5:2];
    c.en        = w[0];
    return c;
  endfunction
endpackage

// File: rtl/tcm_cfg_reg.sv
module tcm_cfg_reg
  import tcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output rgn_cfg_t    cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (wr) cfg <= unpack_cfg(wdata);
  end
endmodule

// File: rtl/tcm_region_decode.sv
module tcm_region_decode
  import tcm_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  rgn_cfg_t          cfg,
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned SHW = 5;
  logic [AW:0]    off;
  logic [SHW-1:0] sh;
  logic [AW-1:0]  above;

  always_comb begin
    off   = {1'b0, addr} - {1'b0, cfg.base_hi, 12'h000};
    sh    = {1'b0, cfg.size_code} + SHW'(9);
    above = off[AW-1:0] >> sh;
    hit   = cfg.en && (cfg.size_code != 4'd0) && !off[AW] && (above == '0);
    idx   = off[IDX_W+1:2];
  end
endmodule

// File: rtl/tcm_code_arb.sv
module tcm_code_arb
  import tcm_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             f_req,
  input  logic [IDX_W-1:0] f_idx,
  input  logic             d_req,
  input  logic             d_we,
  input  logic [BEW-1:0]   d_be,
  input  logic [IDX_W-1:0] d_idx,
  input  logic [DW-1:0]    d_wdata,
  output logic             f_grant,
  output logic             m_en,
  output logic             m_we,
  output logic [BEW-1:0]   m_be,
  output logic [IDX_W-1:0] m_idx,
  output logic [DW-1:0]    m_wdata
);
  always_comb begin
    f_grant = !d_req;
    m_en    = d_req || f_req;
    m_we    = d_req && d_we;
    m_be    = d_req ? d_be : {BEW{1'b1}};
    m_idx   = d_req ? d_idx : f_idx;
    m_wdata = d_req ? d_wdata : '0;
  end
endmodule

// File: rtl/tcm_region_ctrl.sv
module tcm_region_ctrl
  import tcm_pkg::*;
#(
  parameter int unsigned CODE_BYTES = 16384,
  parameter int unsigned DATA_BYTES = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        i_valid,
  output logic        i_ready,
  input  logic [31:0] i_addr,
  output logic        i_uncached,
  output logic        i_fwd_valid,
  input  logic        i_fwd_ready,
  output logic [31:0] i_fwd_addr,
  input  logic        d_valid,
  output logic        d_ready,
  input  logic        d_we,
  input  logic [3:0]  d_be,
  input  logic [31:0] d_addr,
  input  logic [31:0] d_wdata,
  output logic        d_uncached,
  output logic        d_fwd_valid,
  input  logic        d_fwd_ready,
  output logic        d_fwd_we,
  output logic [3:0]  d_fwd_be,
  output logic [31:0] d_fwd_addr,
  output logic [31:0] d_fwd_wdata,
  output logic        itcm_en,
  output logic        itcm_we,
  output logic [3:0]  itcm_be,
  output logic [$clog2(CODE_BYTES)-3:0] itcm_idx,
  output logic [31:0] itcm_wdata,
  output logic        dtcm_en,
  output logic        dtcm_we,
  output logic [3:0]  dtcm_be,
  output logic [$clog2(DATA_BYTES)-3:0] dtcm_idx,
  output logic [31:0] dtcm_wdata
);
  localparam int unsigned CIW = $clog2(CODE_BYTES) - 2;
  localparam int unsigned DIW = $clog2(DATA_BYTES) - 2;

  rgn_cfg_t cfg_q [NUM_RGN];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cfg
    tcm_cfg_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_we && (cfg_sel == 1'(g))),
      .wdata (cfg_wdata),
      .cfg   (cfg_q[g])
    );
  end

  logic           f_code_hit, d_code_hit, d_data_hit;
  logic [CIW-1:0] f_code_idx, d_code_idx;
  logic [DIW-1:0] d_data_idx;

  tcm_region_decode #(.IDX_W(CIW)) u_dec_fc (
    .cfg (cfg_q[RGN_CODE]), .addr (i_addr), .hit (f_code_hit), .idx (f_code_idx)
  );
  tcm_region_decode #(.IDX_W(CIW)) u_dec_dc (
    .cfg (cfg_q[RGN_CODE]), .addr (d_addr), .hit (d_code_hit), .idx (d_code_idx)
  );
  tcm_region_decode #(.IDX_W(DIW)) u_dec_dd (
    .cfg (cfg_q[RGN_DATA]), .addr (d_addr), .hit (d_data_hit), .idx (d_data_idx)
  );

  logic d_to_data, d_to_code, d_local, f_grant;

  always_comb begin
    d_to_data = d_data_hit;
    d_to_code = d_code_hit && !d_data_hit;
    d_local   = d_to_data || d_to_code;
  end

  tcm_code_arb #(.IDX_W(CIW)) u_arb (
    .f_req   (i_valid && f_code_hit),
    .f_idx   (f_code_idx),
    .d_req   (d_valid && d_to_code),
    .d_we    (d_we),
    .d_be    (d_be),
    .d_idx   (d_code_idx),
    .d_wdata (d_wdata),
    .f_grant (f_grant),
    .m_en    (itcm_en),
    .m_we    (itcm_we),
    .m_be    (itcm_be),
    .m_idx   (itcm_idx),
    .m_wdata (itcm_wdata)
  );

  always_comb begin
    i_ready     = f_code_hit ? f_grant : i_fwd_ready;
    i_uncached  = i_valid && f_code_hit;
    i_fwd_valid = i_valid && !f_code_hit;
    i_fwd_addr  = i_addr;

    d_ready     = d_local ? 1'b1 : d_fwd_ready;
    d_uncached  = d_valid && d_local;
    d_fwd_valid = d_valid && !d_local;
    d_fwd_we    = d_we;
    d_fwd_be    = d_be;
    d_fwd_addr  = d_addr;
    d_fwd_wdata = d_wdata;

    dtcm_en     = d_valid && d_to_data;
    dtcm_we     = d_valid && d_to_data && d_we;
    dtcm_be     = d_be;
    dtcm_idx    = d_data_idx;
    dtcm_wdata  = d_wdata;
  end
endmodule

// File: rtl/tcm_region_ctrl_chk.sv
module tcm_region_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        i_valid,
  input logic        i_ready,
  input logic [31:0] i_addr,
  input logic        i_uncached,
  input logic        i_fwd_valid,
  input logic [31:0] i_fwd_addr,
  input logic        d_valid,
  input logic        d_ready,
  input logic        d_we,
  input logic [31:0] d_addr,
  input logic        d_uncached,
  input logic        d_fwd_valid,
  input logic        d_fwd_ready,
  input logic [31:0] d_fwd_addr,
  input logic        itcm_en,
  input logic        itcm_we,
  input logic        dtcm_en
);
  p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!itcm_en && !dtcm_en));
  p_fetch_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_uncached && !(d_valid && d_uncached && !dtcm_en)) |-> (i_ready && itcm_en && !i_fwd_valid));
  p_data_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dtcm_en |-> (d_valid && d_uncached && d_ready && !d_fwd_valid));
  p_load_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    itcm_we |-> (d_valid && d_we && d_uncached && d_ready && !dtcm_en));
  p_data_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_uncached && d_valid && d_uncached && !dtcm_en) |-> (!i_ready && itcm_en));
  p_data_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_fwd_valid |-> (!d_uncached && d_fwd_addr == d_addr && d_ready == d_fwd_ready));
  p_fetch_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    i_fwd_valid |-> (!i_uncached && i_fwd_addr == i_addr));
endmodule

bind tcm_region_ctrl tcm_region_ctrl_chk u_chk (.*);

// File: tb/sim_tcm_region_ctrl.sv
module sim_tcm_region_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic i_valid = 0, i_fwd_ready = 0, d_valid = 0, d_we = 0, d_fwd_ready = 0;
  logic [31:0] i_addr = 0, d_addr = 0, d_wdata = 0;
  logic [3:0] d_be = 0;
  logic i_ready, i_uncached, i_fwd_valid, d_ready, d_uncached, d_fwd_valid, d_fwd_we;
  logic [31:0] i_fwd_addr, d_fwd_addr, d_fwd_wdata, itcm_wdata, dtcm_wdata;
  logic [3:0] d_fwd_be, itcm_be, dtcm_be;
  logic itcm_en, itcm_we, dtcm_en, dtcm_we;
  logic [11:0] itcm_idx;
  logic [10:0] dtcm_idx;

  int checks = 0, errors = 0;
  bit [31:0] icfg = 0, dcfg = 0;

  always #10 clk = ~clk;

  tcm_region_ctrl u0 (.*);

  function automatic bit in_win(bit [31:0] c, bit [31:0] a);
    longint unsigned b, lim;
    if (!c[0] || c[5:2] == 0) return 0;
    b = {32'h0, c[31:12], 12'h000};
    lim = b + (64'd1 << (int'(c[5:2]) + 9));
    return (longint'(a) >= b) && (longint'(a) < lim);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_cfg(bit sel, bit [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (sel) dcfg = v; else icfg = v;
  endtask

  task automatic apply(string tag, bit iv, bit [31:0] ia, bit ifr,
                       bit dv, bit dw, bit [3:0] be, bit [31:0] da, bit [31:0] wd, bit dfr);
    bit ihr, ddr, dir, dcode, eiten, eitwe, ed_local;
    bit [11:0] eiidx;
    bit [10:0] edidx;
    @(negedge clk);
    i_valid = iv; i_addr = ia; i_fwd_ready = ifr;
    d_valid = dv; d_we = dw; d_be = be; d_addr = da; d_wdata = wd; d_fwd_ready = dfr;
    #2;
    ihr = in_win(icfg, ia);
    ddr = in_win(dcfg, da);
    dir = in_win(icfg, da) && !ddr;
    ed_local = ddr || dir;
    dcode = dv && dir;
    eiten = dcode || (iv && ihr);
    eitwe = dcode && dw;
    eiidx = dcode ? 12'((da - {icfg[31:12], 12'h0}) >> 2) : 12'((ia - {icfg[31:12], 12'h0}) >> 2);
    edidx = 11'((da - {dcfg[31:12], 12'h0}) >> 2);
    chk({tag, " ctl"},
        {i_ready, i_uncached, i_fwd_valid, d_ready, d_uncached, d_fwd_valid,
         itcm_en, itcm_we, dtcm_en, dtcm_we},
        {(ihr ? !dcode : ifr), iv && ihr, iv && !ihr, (ed_local ? 1'b1 : dfr),
         dv && ed_local, dv && !ed_local, eiten, eitwe, dv && ddr, dv && ddr && dw});
    if (eiten) chk({tag, " itcm idx"}, {itcm_idx, itcm_be, itcm_wdata},
                   {eiidx, (dcode ? be : 4'hF), (dcode ? wd : 32'h0)});
    if (dv && ddr) chk({tag, " dtcm idx"}, {dtcm_idx, dtcm_be, dtcm_wdata}, {edidx, be, wd});
    if (dv && !ed_local) chk({tag, " fwd"}, {d_fwd_addr, d_fwd_wdata},  {da, wd});
  endtask

  initial begin : watchdog
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: both windows disabled out of reset
    apply("R1 reset code addr", 1, 32'h0000_0100, 1, 1, 0, 4'hF, 32'h0000_0040, 0, 0);
    apply("R1 reset data addr", 1, 32'h0000_0000, 0, 1, 1, 4'h3, 32'h1000_0000, 32'h55, 1);
    // R2: write takes effect only after its edge
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h15;
    i_valid = 1; i_addr = 32'h10; i_fwd_ready = 0; d_valid = 0;
    #2 chk("R2 old cfg before edge", {i_uncached, i_fwd_valid}, {1'b0, 1'b1});
    @(negedge clk);
    cfg_we = 0; icfg = 32'h15;
    wr_cfg(1, 32'h1000_0011);
    // R3 fetch hits and edges
    apply("R3 fetch base", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    apply("R3 fetch top", 1, 32'h3FFC, 0, 0, 0, 0, 0, 0, 0);
    apply("R7 fetch past top", 1, 32'h4000, 1, 0, 0, 0, 0, 0, 0);
    // R4 data store
    apply("R4 data base wr", 0, 0, 0, 1, 1, 4'h5, 32'h1000_0000, 32'hA5A5_0001, 0);
    apply("R4 data top rd", 0, 0, 0, 1, 0, 4'hF, 32'h1000_1FFC, 0, 0);
    apply("R7 data past top", 0, 0, 0, 1, 1, 4'hF, 32'h1000_2000, 32'h77, 0);
    // R5 code load through data port
    apply("R5 load code", 0, 0, 0, 1, 1, 4'hF, 32'h0000_0020, 32'hDEAD_BEEF, 0);
    // R6 conflict, then fetch proceeds
    apply("R6 conflict", 1, 32'h0000_0100, 1, 1, 1, 4'hF, 32'h0000_0200, 32'h1, 0);
    apply("R6 fetch after", 1, 32'h0000_0100, 1, 1, 0, 4'hF, 32'h1000_0004, 0, 0);
    // R2 size code 0 and enable clear
    wr_cfg(0, 32'h0000_0001);
    apply("R2 size0 empty", 1, 32'h0, 0, 1, 0, 4'hF, 32'h8, 0, 1);
    wr_cfg(0, 32'h0000_0014);
    apply("R2 enable off", 1, 32'h0, 1, 1, 0, 4'hF, 32'h8, 0, 0);
    // R8 overlap: data window wins
    wr_cfg(0, 32'h1000_0015);
    apply("R8 overlap", 1, 32'h1000_0010, 0, 1, 1, 4'hF, 32'h1000_0010, 32'h9, 0);
    // R9 oversize window wraps
    wr_cfg(0, 32'h0000_001D);
    apply("R9 wrap fetch", 1, 32'h0000_4004, 0, 0, 0, 0, 0, 0, 0);
    wr_cfg(1, 32'h2000_0019);
    apply("R9 wrap data", 0, 0, 0, 1, 0, 4'hF, 32'h2000_2008, 0, 0);
    // random mix, R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 600; n++) begin
      bit [31:0] ia, da, ib, db;
      if (n % 40 == 0) begin
        case ($urandom_range(0, 3))
          0: begin wr_cfg(0, 32'h15); wr_cfg(1, 32'h1000_0011); end
          1: begin wr_cfg(0, {$urandom_range(0, 3) == 0 ? 20'h10000 : 20'($urandom_range(0, 7)),
                              6'h0, 4'($urandom), 1'b0, 1'($urandom)});
                   wr_cfg(1, 32'h1000_0011); end
          2: begin wr_cfg(1, {20'h10000 + 20'($urandom_range(0, 3)), 6'h0, 4'($urandom_range(0, 6)), 2'b01}); end
          default: begin wr_cfg(0, 32'h1000_0015); wr_cfg(1, 32'h1000_0011); end
        endcase
      end
      ib = {icfg[31:12], 12'h0};
      db = {dcfg[31:12], 12'h0};
      ia = ib + 32'($urandom_range(0, 20000)) - 32'd64;
      da = ($urandom_range(0, 1) ? db : ib) + 32'($urandom_range(0, 20000)) - 32'd64;
      apply("R6 R7 random", 1'($urandom), {ia[31:2], 2'b00}, 1'($urandom),
            1'($urandom), 1'($urandom), 4'($urandom), {da[31:2], 2'b00}, $urandom, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule